// File: doc/BRIEF.md
# Carry-Save Serial/Parallel Multiplier

This block multiplies a two's-complement data word, presented one bit per clock with the least significant bit first, by a two's-complement coefficient that is presented in parallel and held steady for the whole computation. A row of AND gates forms the bit-products of the coefficient with the current data bit. A row of full adders adds them to a carry-save accumulator in which every stage keeps its own saved sum bit and its own saved carry bit. No carry ripples across stages, so the critical path is one gate and one full adder, independent of `WC`.

After each addition the accumulator halves itself. Every sum bit moves one stage toward the least significant end, every carry stays in its stage, and the top stage feeds its own sum back to itself as sign extension. The bit that leaves the bottom stage is the next product bit. On the cycle that carries the sign bit of the data, the bit-product row is inverted and a carry of one enters at the least significant end, so that cycle subtracts. After the `WD` data bits, the block forces zeros for `WC-1` more cycles to drain the upper product bits. The serial input is not used in that phase.

A user pulses `start` together with the data LSB, then streams the remaining data bits. The product appears on `p_out`, one bit per cycle, qualified by `p_valid`.

Top module: `csa_serial_mult`

## Requirements
- R1: While reset is held, and after its release until the first start, `p_valid` and `p_out` are 0.
- R2: A clock edge with `start` high clears the accumulator and takes `x_in` as data bit 0. Each later edge of the run takes the next data bit. The k-th cycle with `p_valid` high (k from 0) presents bit k of the product on `p_out`.
- R3: `coef` is a signed `WC`-bit value and the data word is a signed `WD`-bit value. The stream carries the low `WD+WC-1` bits of their exact signed product, the most negative operands included: most negative times most negative gives a stream of zeros ending in a single 1.
- R4: The data bit taken at index `WD-1` counts with negative weight. For example, data of all ones (value -1) yields the stream of `-coef`.
- R5: During the `WC-1` cycles after the data bits, `x_in` has no effect on the product.
- R6: `p_valid` rises in the cycle after a start edge, stays high for exactly `WD+WC-1` consecutive cycles, and then falls unless another start arrives.
- R7: Whenever `p_valid` is low, `p_out` is 0.
- R8: A start arriving while a run is in progress abandons that run. The new run's stream is the product of the new operands, and `p_valid` stays high throughout.
- R9: A start on the edge right after a run's last processing edge gives an unbroken `p_valid` run. The second product is correct and no state carries over from the first run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new product; `x_in` carries the data LSB in this cycle |
| x_in | input | 1 | Serial data bit, LSB first |
| coef | input | WC | Signed coefficient, held stable during a run |
| p_out | output | 1 | Serial product bit, LSB first |
| p_valid | output | 1 | High while `p_out` carries a product bit |

## Verification
The bench targets operand values that stress the sign handling: the most negative coefficient and data, all-ones data, zero, and mixes of signs. A design that added instead of subtracted on the sign cycle, or that dropped the injected carry, would be off by a multiple of the coefficient or by one unit at the data sign position. It also drives ones and random bits during the drain phase, where a design that kept sampling `x_in` would corrupt the upper bits. Restarts in mid-run and back-to-back starts expose stale sum, carry or injection state, and the length of the valid window is checked against `WD+WC-1`.

// File: rtl/csa_serial_mult.sv
module csa_serial_mult #(
  parameter int WC = 5,
  parameter int WD = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          x_in,
  input  logic [WC-1:0] coef,
  output logic          p_out,
  output logic          p_valid
);
  localparam int NCYC = WD + WC - 1;
  localparam int CW   = $clog2(NCYC + 1);

  logic [CW-1:0] cnt, k;
  logic          busy, active, xb, neg, cin, inj_q;
  logic [WC-1:0] s_q, c_q, s_in, c_in, pp, fs, fc;

  assign active = start | busy;
  assign k      = start ? '0 : cnt;
  assign xb     = active & (int'(k) < WD) & x_in;
  assign neg    = active & (int'(k) == WD - 1);
  assign s_in   = start ? '0 : s_q;
  assign c_in   = start ? '0 : c_q;
  assign cin    = neg | (~start & inj_q);

  for (genvar i = 0; i < WC; i++) begin : g_stage
    assign pp[i] = (coef[i] & xb) ^ neg;
    assign fs[i] = pp[i] ^ s_in[i] ^ c_in[i];
    assign fc[i] = (pp[i] & s_in[i]) | (pp[i] & c_in[i]) | (s_in[i] & c_in[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q     <= '0;
      c_q     <= '0;
      inj_q   <= 1'b0;
      cnt     <= '0;
      busy    <= 1'b0;
      p_out   <= 1'b0;
      p_valid <= 1'b0;
    end else if (active) begin
      s_q     <= {fs[WC-1], fs[WC-1:1]};
      c_q     <= fc;
      inj_q   <= fs[0] & cin;
      p_out   <= fs[0] ^ cin;
      p_valid <= 1'b1;
      cnt     <= k + 1'b1;
      busy    <= (int'(k) != NCYC - 1);
    end else begin
      p_out   <= 1'b0;
      p_valid <= 1'b0;
    end
  end
endmodule

module csa_serial_mult_chk #(
  parameter int WC = 5,
  parameter int WD = 8
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic p_out,
  input logic p_valid
);
  localparam int NCYC = WD + WC - 1;
  localparam int LW   = $clog2(NCYC + 1);
  logic [LW-1:0] len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            len <= '0;
    else if (start)                        len <= LW'(1);
    else if (len != '0 && int'(len) < NCYC) len <= len + 1'b1;
    else                                   len <= '0;
  end

  a_r6_valid_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> p_valid);
  a_r6_valid_window: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid == (len != '0));
  a_r6_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_valid) |-> $past(start));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !p_valid |-> !p_out);
endmodule

bind csa_serial_mult csa_serial_mult_chk #(.WC(WC), .WD(WD)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .p_out(p_out), .p_valid(p_valid)
);

// File: tb/sim_csa_serial_mult.sv
`timescale 1ns/1ps
module sim_csa_serial_mult;
  localparam int WC = 5;
  localparam int WD = 8;
  localparam int N  = WD + WC - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, x_in = 1'b0;
  logic [WC-1:0] coef = '0;
  logic p_out, p_valid;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  csa_serial_mult #(.WC(WC), .WD(WD)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
    .coef(coef), .p_out(p_out), .p_valid(p_valid)
  );

  function automatic logic [N-1:0] expect_prod(logic signed [WC-1:0] a,
                                               logic signed [WD-1:0] x);
    longint p = longint'(a) * longint'(x);
    return p[N-1:0];
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drain: 0 = zeros, 1 = ones, 2 = random bits on x_in after the data
  task automatic run(logic signed [WC-1:0] a, logic signed [WD-1:0] x,
                     int drain, string req);
    logic [N-1:0] got = '0;
    bit vok = 1'b1;
    coef = a;
    for (int k = 0; k < N; k++) begin
      start = (k == 0);
      if (k < WD) x_in = x[k];
      else x_in = (drain == 0) ? 1'b0 : (drain == 1) ? 1'b1 : 1'($urandom);
      @(negedge clk);
      got[k] = p_out;
      if (!p_valid) vok = 1'b0;
    end
    start = 1'b0;
    x_in  = 1'b0;
    check(got == expect_prod(a, x), req, got, expect_prod(a, x));
    check(vok, "R6 valid held", vok, 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!p_valid && !p_out, "R1 reset", {p_valid, p_out}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!p_valid && !p_out, "R1 idle after reset", {p_valid, p_out}, 0);

    run(5'sd3, 8'sd5, 0, "R2 small positive");
    @(negedge clk);
    check(!p_valid, "R6 valid falls after run", p_valid, 0);
    check(!p_out, "R7 idle output", p_out, 0);
    run(-5'sd16, -8'sd128, 0, "R3 most negative both");
    run(-5'sd16, 8'sd127, 0, "R3 most negative coef");
    run(5'sd15, -8'sd128, 0, "R3 most negative data");
    run(5'sd11, -8'sd1, 0, "R4 data minus one");
    run(-5'sd7, -8'sd1, 0, "R4 negative coef data minus one");
    run(5'sd0, -8'sd77, 2, "R3 zero coef");
    run(-5'sd9, 8'sd0, 1, "R3 zero data");
    run(-5'sd13, 8'sd93, 1, "R5 drain ones");
    run(-5'sd13, 8'sd93, 0, "R5 drain zeros");
    run(5'sd7, -8'sd45, 1, "R5 drain ones negative data");

    coef = 5'sd9;
    for (int k = 0; k < 4; k++) begin
      start = (k == 0);
      x_in  = 1'b1;
      @(negedge clk);
    end
    run(-5'sd6, 8'sd101, 2, "R8 restart mid-run");

    run(5'sd15, 8'sd127, 0, "R9 back-to-back first");
    run(-5'sd1, -8'sd2, 0, "R9 back-to-back second");
    @(negedge clk);

    for (int t = 0; t < 200; t++) begin
      run(5'($urandom), 8'($urandom), 2, "R3 random");
      if (($urandom & 3) == 0) @(negedge clk);
    end
    @(negedge clk);
    check(!p_valid && !p_out, "R7 final idle", {p_valid, p_out}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule